// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running safety timer that counts on its own low-speed clock enable (`tick_i`), kept apart from the main system clock domain's software flow. A 12-bit down-counter is decremented once per prescaled tick. If software does not refresh the counter in time, the block drives a system-reset pulse. Software controls the block only through 16-bit key writes. One key arms the timer, one reloads the counter, and one opens the configuration registers for writing.

Once armed, the timer cannot be stopped by any write. Only the reset pulse it generates, or the external reset, returns it to idle. A sticky flag records that a watchdog reset occurred, and software clears it. A sleep indication is accepted, and counting continues unchanged while it is high.

Top module: `keyed_wdog`

## Requirements
- R1: After `rst_ni` is released, `running_o`=0, `cnt_o`=0xFFF, `rld_o`=0xFFF, `div_o`=0, `unlocked_o`=0, `wdg_rst_o`=0 and `rst_flag_o`=0.
- R2: A key write of 0xCCCC sets `running_o` and clears the prescaler. Counting starts from the counter's current value, which is 0xFFF from idle. Only cycles with `tick_i`=1 advance the prescaler, so `cnt_o` holds while `tick_i`=0.
- R3: While running, `cnt_o` drops by one on every D-th tick, where D = 4 << code for `div_o` codes 0..5 and D = 256 for codes 6 and 7.
- R4: If a prescaled step arrives while `cnt_o` is 0, `wdg_rst_o` goes high in the next cycle and stays high for exactly 4 cycles. With the tick enable high every cycle, the rise comes D*(reload+1) cycles after the refresh edge.
- R5: A key write of 0xAAAA loads `rld_o` into the counter and clears the prescaler, which delays the reset pulse.
- R6: A key write of 0x5555 sets `unlocked_o`. Writes through `div_we_i` and `rld_we_i` take effect only while `unlocked_o`=1. Otherwise they are ignored.
- R7: Any key write other than 0x5555, including 0xCCCC and 0xAAAA, clears `unlocked_o`.
- R8: While running, no key value and no register write clears `running_o`. It falls only when the reset pulse starts.
- R9: When the reset pulse starts, the block returns to idle: `running_o`=0, `cnt_o`=0xFFF, `rld_o`=0xFFF, `div_o`=0 and `unlocked_o`=0.
- R10: `rst_flag_o` is set when the reset pulse starts. A cycle with `flag_clr_i`=1 clears it, and a new pulse takes priority over the clear.
- R11: `sleep_i` has no effect on counting or on the timeout.
- R12: Key writes made while `wdg_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Low-speed clock enable |
| sleep_i | input | 1 | Low-power mode indication |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 16 | Key value |
| div_we_i | input | 1 | Prescaler code write strobe |
| div_i | input | PSC_W | Prescaler code |
| rld_we_i | input | 1 | Reload value write strobe |
| rld_i | input | CNT_W | Reload value |
| flag_clr_i | input | 1 | Clear watchdog-reset flag |
| cnt_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Watchdog armed |
| unlocked_o | output | 1 | Configuration writes open |
| div_o | output | PSC_W | Current prescaler code |
| rld_o | output | CNT_W | Current reload value |
| wdg_rst_o | output | 1 | System reset pulse |
| rst_flag_o | output | 1 | Sticky watchdog-reset flag |

## Verification
Several properties are checked on every cycle:
- the reset pulse width and its flag;
- that the armed state ends only at a pulse;
- that locked reload writes are ignored;
- that the counter holds without a tick and never moves by more than one per cycle;
- that keys are ignored during the pulse.

Other behaviour depends on a whole timeline and is shown only by the bench scenarios:
- the exact cycle of the reset for every prescaler code;
- the full 0xFFF countdown after arming;
- how repeated refreshes postpone the timeout;
- the return of every register to its default after a pulse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam logic [15:0] KEY_KICK   = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;

  // divide ratio for a prescaler code; codes above max_code saturate
  function automatic int unsigned div_ratio(int unsigned code, int unsigned max_code);
    return 4 << ((code > max_code) ? max_code : code);
  endfunction
endpackage

// File: rtl/kwd_keyctl.sv
module kwd_keyctl #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [15:0]      key_i,
  input  logic             div_we_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic             fire_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             kick_o,
  output logic             running_o,
  output logic             unlocked_o,
  output logic [PSC_W-1:0] div_o,
  output logic [CNT_W-1:0] rld_o
);
  import kwd_pkg::*;

  logic key_ok;
  assign key_ok  = key_we_i && !busy_i;
  assign start_o = key_ok && (key_i == KEY_START);
  assign kick_o  = key_ok && (key_i == KEY_KICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o  <= 1'b0;
      unlocked_o <= 1'b0;
      div_o      <= '0;
      rld_o      <= '1;
    end else if (fire_i) begin
      running_o  <= 1'b0;
      unlocked_o <= 1'b0;
      div_o      <= '0;
      rld_o      <= '1;
    end else begin
      if (start_o) running_o <= 1'b1;
      if (key_ok) unlocked_o <= (key_i == KEY_UNLOCK);
      if (div_we_i && unlocked_o) div_o <= div_i;
      if (rld_we_i && unlocked_o) rld_o <= rld_i;
    end
  end
endmodule

// File: rtl/kwd_presc.sv
module kwd_presc #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             low_power_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             step_o
);
  localparam int NCODE    = 2 ** PSC_W;
  localparam int MAX_CODE = NCODE - 2;
  localparam int PC_W     = MAX_CODE + 2;

  logic [PC_W-1:0]  pc_q;
  logic [NCODE-1:0] hit;
  logic             tick_act, tc;

  // ticks count the same way in normal and low-power operation
  assign tick_act = low_power_i ? tick_i : tick_i;

  for (genvar c = 0; c < NCODE; c++) begin : g_tc
    localparam int unsigned LIM = kwd_pkg::div_ratio(c, MAX_CODE);
    assign hit[c] = (code_i == PSC_W'(c)) && (pc_q == PC_W'(LIM - 1));
  end

  assign tc     = |hit;
  assign step_o = run_i && tick_act && tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (clr_i)             pc_q <= '0;
    else if (run_i && tick_act) pc_q <= tc ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/kwd_downcnt.sv
module kwd_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  assign fire_o = step_i && !load_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '1;
    else if (fire_o) cnt_o <= '1;
    else if (load_i) cnt_o <= load_val_i;
    else if (step_i) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/kwd_rstgen.sv
module kwd_rstgen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic flag_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      flag_o <= 1'b0;
    end else begin
      if (fire_i)       left_q <= PW'(PULSE_LEN);
      else if (pulse_o) left_q <= left_q - 1'b1;
      if (fire_i)       flag_o <= 1'b1;
      else if (clr_i)   flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CNT_W     = 12,
  parameter int PSC_W     = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sleep_i,
  input  logic             key_we_i,
  input  logic [15:0]      key_i,
  input  logic             div_we_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             unlocked_o,
  output logic [PSC_W-1:0] div_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             wdg_rst_o,
  output logic             rst_flag_o
);
  logic start, kick, step, fire;

  kwd_keyctl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_keyctl (
    .clk_i, .rst_ni, .key_we_i, .key_i, .div_we_i, .div_i, .rld_we_i, .rld_i,
    .fire_i(fire), .busy_i(wdg_rst_o), .start_o(start), .kick_o(kick),
    .running_o, .unlocked_o, .div_o, .rld_o
  );

  kwd_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i, .rst_ni, .run_i(running_o), .tick_i, .low_power_i(sleep_i),
    .clr_i(start | kick | fire), .code_i(div_o), .step_o(step)
  );

  kwd_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(kick), .load_val_i(rld_o), .step_i(step),
    .cnt_o, .fire_o(fire)
  );

  kwd_rstgen #(.PULSE_LEN(PULSE_LEN)) u_rstgen (
    .clk_i, .rst_ni, .fire_i(fire), .clr_i(flag_clr_i),
    .pulse_o(wdg_rst_o), .flag_o(rst_flag_o)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W     = 12,
  parameter int PSC_W     = 3,
  parameter int PULSE_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             key_we_i,
  input logic             rld_we_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             running_o,
  input logic             unlocked_o,
  input logic [PSC_W-1:0] div_o,
  input logic [CNT_W-1:0] rld_o,
  input logic             wdg_rst_o,
  input logic             rst_flag_o
);
  logic [7:0] plen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        plen_q <= '0;
    else if (wdg_rst_o) plen_q <= plen_q + 1'b1;
    else                plen_q <= '0;
  end

  assert_tick_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !tick_i && !key_we_i) |=> $stable(cnt_o));

  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !key_we_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 12'd1 || $rose(wdg_rst_o)));

  assert_pulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdg_rst_o) |-> (plen_q == 8'(PULSE_LEN)));

  assert_locked_rld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_we_i && !unlocked_o) |=> ($stable(rld_o) || $rose(wdg_rst_o)));

  assert_no_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> $rose(wdg_rst_o));

  assert_idle_in_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |-> (!running_o && !unlocked_o && div_o == '0));

  assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdg_rst_o) |-> rst_flag_o);

  assert_busy_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_rst_o && key_we_i) |=> !running_o);
endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i, .rst_ni, .tick_i, .key_we_i, .rld_we_i, .cnt_o, .running_o, .unlocked_o,
  .div_o, .rld_o, .wdg_rst_o, .rst_flag_o
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
  localparam int CNT_W = 12;
  localparam int PSC_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b1, sleep_i = 1'b0, key_we_i = 1'b0;
  logic [15:0] key_i = '0;
  logic div_we_i = 1'b0, rld_we_i = 1'b0, flag_clr_i = 1'b0;
  logic [PSC_W-1:0] div_i = '0;
  logic [CNT_W-1:0] rld_i = '0;
  logic [CNT_W-1:0] cnt_o, rld_o;
  logic [PSC_W-1:0] div_o;
  logic running_o, unlocked_o, wdg_rst_o, rst_flag_o;

  keyed_wdog dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .sleep_i, .key_we_i, .key_i, .div_we_i, .div_i,
    .rld_we_i, .rld_i, .flag_clr_i, .cnt_o, .running_o, .unlocked_o, .div_o, .rld_o,
    .wdg_rst_o, .rst_flag_o
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compares reset pulses against the scoreboard
  logic prev_rst = 1'b0;
  int plen = 0;
  always @(negedge clk) begin : mon
    int e;
    if (wdg_rst_o && !prev_rst) begin
      if (exp_q.size() == 0) chk("R4 unexpected pulse cycle", cyc, -1);
      else begin
        e = exp_q.pop_front();
        chk("R4 pulse start cycle", cyc, e);
      end
    end
    if (wdg_rst_o) plen++;
    else if (prev_rst) begin
      chk("R4 pulse length", plen, 4);
      plen = 0;
    end
    prev_rst = wdg_rst_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  function automatic int div_of(int code);
    return (code >= 6) ? 256 : (4 << code);
  endfunction

  task automatic key(input logic [15:0] k);
    @(negedge clk); key_we_i = 1'b1; key_i = k;
    @(negedge clk); key_we_i = 1'b0;
  endtask

  task automatic wr_rld(input int v);
    @(negedge clk); rld_we_i = 1'b1; rld_i = CNT_W'(v);
    @(negedge clk); rld_we_i = 1'b0;
  endtask

  task automatic wr_div(input int c);
    @(negedge clk); div_we_i = 1'b1; div_i = PSC_W'(c);
    @(negedge clk); div_we_i = 1'b0;
  endtask

  // called at the negedge right after the refresh/start edge
  task automatic expect_fire(int code, int r);
    exp_q.push_back(cyc + div_of(code) * (r + 1));
  endtask

  task automatic wait_drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk("R4 expected pulse seen", exp_q.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic arm(int code, int r);
    key(16'h5555); wr_div(code); wr_rld(r);
    key(16'hCCCC); key(16'hAAAA);
    expect_fire(code, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 running", running_o, 0);
    chk("R1 cnt", cnt_o, 'hFFF);
    chk("R1 rld", rld_o, 'hFFF);
    chk("R1 div", div_o, 0);
    chk("R1 unlocked", unlocked_o, 0);
    chk("R1 wdg_rst", wdg_rst_o, 0);
    chk("R1 flag", rst_flag_o, 0);

    key(16'h5555); chk("R6 unlock", unlocked_o, 1);
    wr_rld(5);     chk("R6 rld write", rld_o, 5);
    wr_div(1);     chk("R6 div write", div_o, 1);
    key(16'h1234); chk("R7 relock", unlocked_o, 0);
    wr_rld(9);     chk("R6 locked rld ignored", rld_o, 5);
    wr_div(4);     chk("R6 locked div ignored", div_o, 1);
    key(16'h5555); wr_div(0);

    key(16'hCCCC);
    chk("R2 running", running_o, 1);
    chk("R2 start count", cnt_o, 'hFFF);
    chk("R7 start relocks", unlocked_o, 0);
    repeat (8) @(negedge clk);
    chk("R3 two steps at div 4", cnt_o, 'hFFD);
    tick_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 hold without tick", cnt_o, 'hFFD);
    tick_i = 1'b1;
    key(16'h0000); chk("R8 still running", running_o, 1);
    sleep_i = 1'b1; // R11
    key(16'hAAAA);
    chk("R5 refresh loads reload", cnt_o, 5);
    chk("R7 refresh relocks", unlocked_o, 0);
    expect_fire(0, 5);
    wr_rld(7); chk("R6 rld ignored while running", rld_o, 5);
    while (!wdg_rst_o) @(negedge clk);
    key(16'hCCCC); // R12: during pulse
    repeat (4) @(negedge clk);
    chk("R11 timeout in sleep", exp_q.size(), 0);
    chk("R12 key ignored in pulse", running_o, 0);
    chk("R9 running", running_o, 0);
    chk("R9 cnt", cnt_o, 'hFFF);
    chk("R9 rld", rld_o, 'hFFF);
    chk("R9 div", div_o, 0);
    chk("R9 unlocked", unlocked_o, 0);
    chk("R10 flag set", rst_flag_o, 1);
    sleep_i = 1'b0;
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk("R10 flag cleared", rst_flag_o, 0);

    // R5: repeated refreshes postpone the timeout (div 32, reload 2 -> 96)
    key(16'h5555); wr_div(3); wr_rld(2); key(16'hCCCC);
    for (int i = 0; i < 3; i++) begin
      key(16'hAAAA);
      repeat (60) @(negedge clk);
    end
    chk("R5 no pulse while refreshed", rst_flag_o, 0);
    key(16'hAAAA); expect_fire(3, 2);
    wait_drain();

    // R3: prescaler codes
    arm(7, 0); wait_drain();
    arm(6, 1); wait_drain();
    arm(2, 3); wait_drain();

    // R2: full count from 0xFFF after start
    key(16'hCCCC);
    exp_q.push_back(cyc + 4 * 4096);
    wait_drain();
    chk("R10 flag after timeout", rst_flag_o, 1);
    summary();
  end
endmodule